// File: doc/BRIEF.md
# SPI Master Transfer Timing Sequencer

This block runs one SPI master transfer at a time from the system clock. It drives an active-low chip-select and a serial clock, shifts a word out on MOSI, and collects a word from MISO. A `start` pulse captures everything the transfer needs: the data word, two per-command selector bits and the programmed timing fields. A one-cycle `done` pulse marks the end of the transfer.

The setup selector picks the gap between chip-select assertion and the first SCK rising edge. It is either half an SCK period or a programmed count. The hold selector picks the gap between chip-select release and `done`. It is either a fixed 17 clocks or a programmed multiple of 32 clocks. The zero and one values of the programmed fields have special meanings, listed below. The SCK half-period comes from a baud field. The bus uses clock mode 0: SCK idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge.

Top module: `spi_xfer_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `done` is 0 and `busy` is 0.
- R2: With `setup_sel`=0, the first SCK rising edge comes H system clocks after the edge at which `cs_n` falls. H is the half-period defined in R7. `setup_len` has no effect.
- R3: With `setup_sel`=1 and `setup_len`=N, where N is from 2 to 127, the first SCK rising edge comes N clocks after `cs_n` falls.
- R4: With `setup_sel`=1, a `setup_len` of 0 gives 128 clocks and a `setup_len` of 1 gives 2 clocks.
- R5: With `hold_sel`=1 and `hold_len`=M, where M is from 1 to 255, `done` rises 32×M clocks after `cs_n` rises. A `hold_len` of 0 gives 8192 clocks.
- R6: With `hold_sel`=0, `done` rises 17 clocks after `cs_n` rises.
- R7: Let H be `baud`, with values 0 and 1 taken as 2. SCK high and low phases each last H clocks, so the period is 2H. Each transfer has exactly 8 rising edges, and SCK is low whenever `cs_n` is high.
- R8: MOSI carries `tx_data` MSB first. It changes only on falling SCK edges. MISO is sampled on rising edges, MSB first. When `cs_n` rises, `rx_data` holds the received word.
- R9: `cs_n` rises at the same clock edge as the 8th falling SCK edge.
- R10: `done` is high for exactly one cycle and only while `cs_n` is high. `busy` is high from the accepted `start` until `done`. A `start` while `busy` is high is ignored, and `cs_n` falls only on an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| setup_sel | input | 1 | 0: half-period setup, 1: programmed setup |
| hold_sel | input | 1 | 0: 17-clock hold, 1: programmed hold |
| setup_len | input | 7 | Programmed setup count |
| hold_len | input | 8 | Programmed hold count in units of 32 clocks |
| baud | input | 8 | SCK half-period in clocks |
| tx_data | input | 8 | Word to send |
| miso | input | 1 | Serial input |
| cs_n | output | 1 | Chip-select, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial output |
| rx_data | output | 8 | Received word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bound checker watches the following on every cycle:
- SCK stays low while chip-select is high.
- MOSI holds steady while SCK is high.
- Chip-select rises only together with a falling SCK edge.
- `done` is a single-cycle pulse that appears only with chip-select released.
- Chip-select falls only after a `start`.

The actual delay lengths need the bench's cycle-counting scenarios, because they depend on captured field values. This covers the 0 and 1 encodings of the setup field, the 0 encoding of the hold field, and baud values clamped to 2. Bit order on both data lines and the rejection of a `start` issued mid-transfer are also shown only by the bench.

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq #(
  parameter int W         = 8,
  parameter int DLY_W     = 7,
  parameter int HLD_W     = 8,
  parameter int BAUD_W    = 8,
  parameter int STD_HOLD  = 17,
  parameter int HOLD_UNIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              setup_sel,
  input  logic              hold_sel,
  input  logic [DLY_W-1:0]  setup_len,
  input  logic [HLD_W-1:0]  hold_len,
  input  logic [BAUD_W-1:0] baud,
  input  logic [W-1:0]      tx_data,
  input  logic              miso,
  output logic              cs_n,
  output logic              sck,
  output logic              mosi,
  output logic [W-1:0]      rx_data,
  output logic              busy,
  output logic              done
);
  localparam int HOLD_MAX = HOLD_UNIT << HLD_W;
  localparam int CNT_W    = $clog2(HOLD_MAX + 1);
  localparam int BIT_W    = $clog2(W);

  typedef enum logic [1:0] {IDLE, SETUP, SHIFT, HOLD} st_t;

  st_t               st;
  logic [BAUD_W-1:0] half_q;
  logic [CNT_W-1:0]  cnt, hold_q, setup_clks, hold_clks;
  logic [BIT_W-1:0]  bit_q;
  logic [W-1:0]      tx_sh, rx_sh;

  wire [BAUD_W-1:0] half_in = (baud < BAUD_W'(2)) ? BAUD_W'(2) : baud;

  always_comb begin
    if (!setup_sel)                   setup_clks = CNT_W'(half_in);
    else if (setup_len == '0)         setup_clks = CNT_W'(1 << DLY_W);
    else if (setup_len == DLY_W'(1))  setup_clks = CNT_W'(2);
    else                              setup_clks = CNT_W'(setup_len);
  end

  always_comb begin
    if (!hold_sel)             hold_clks = CNT_W'(STD_HOLD);
    else if (hold_len == '0)   hold_clks = CNT_W'(HOLD_MAX);
    else                       hold_clks = CNT_W'(hold_len) * CNT_W'(HOLD_UNIT);
  end

  assign mosi = tx_sh[W-1];
  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      cs_n    <= 1'b1;
      sck     <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      hold_q  <= '0;
      half_q  <= '0;
      bit_q   <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          cs_n   <= 1'b0;
          tx_sh  <= tx_data;
          cnt    <= setup_clks - CNT_W'(1);
          hold_q <= hold_clks;
          half_q <= half_in;
          bit_q  <= '0;
          st     <= SETUP;
        end
        SETUP: if (cnt == '0) begin
          sck   <= 1'b1;
          rx_sh <= {rx_sh[W-2:0], miso};
          cnt   <= CNT_W'(half_q) - CNT_W'(1);
          st    <= SHIFT;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
        SHIFT: if (cnt != '0) begin
          cnt <= cnt - CNT_W'(1);
        end else begin
          cnt <= CNT_W'(half_q) - CNT_W'(1);
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[W-2:0], miso};
          end else begin
            sck <= 1'b0;
            if (bit_q == BIT_W'(W-1)) begin
              cs_n    <= 1'b1;
              rx_data <= rx_sh;
              cnt     <= hold_q - CNT_W'(1);
              st      <= HOLD;
            end else begin
              tx_sh <= tx_sh << 1;
              bit_q <= bit_q + BIT_W'(1);
            end
          end
        end
        HOLD: if (cnt == '0) begin
          done <= 1'b1;
          st   <= IDLE;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module spi_xfer_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic busy,
  input logic done
);
  // R7
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sck));
  // R8
  mosi_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));
  // R9
  cs_release_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $fell(sck));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  // R10
  cs_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(start));
endmodule

bind spi_xfer_seq spi_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cs_n(cs_n),
  .sck(sck), .mosi(mosi), .busy(busy), .done(done)
);

// File: tb/spi_xfer_seq_bench.sv
`timescale 1ns/1ps
module spi_xfer_seq_bench;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic setup_sel = 1'b0, hold_sel = 1'b0;
  logic [6:0] setup_len = '0;
  logic [7:0] hold_len = '0, baud = '0;
  logic [W-1:0] tx_data = '0, rx_pat = '0;
  logic miso;
  logic cs_n, sck, mosi, busy, done;
  logic [W-1:0] rx_data;
  int checks = 0, errors = 0, idx = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_xfer_seq u_spi_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .setup_sel(setup_sel),
    .hold_sel(hold_sel), .setup_len(setup_len), .hold_len(hold_len),
    .baud(baud), .tx_data(tx_data), .miso(miso), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .rx_data(rx_data), .busy(busy), .done(done)
  );

  always @(negedge cs_n) idx = 0;
  always @(negedge sck) if (!cs_n) idx = idx + 1;
  assign miso = (idx < W) ? rx_pat[W-1-idx] : 1'b0;

  function automatic int exp_half(int b);
    return (b < 2) ? 2 : b;
  endfunction
  function automatic int exp_setup(int sel, int n, int b);
    if (sel == 0) return exp_half(b);
    if (n == 0) return 128;
    if (n == 1) return 2;
    return n;
  endfunction
  function automatic int exp_hold(int sel, int m);
    if (sel == 0) return 17;
    if (m == 0) return 8192;
    return 32 * m;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_xfer(int ss, int hs, int sl, int hl, int b,
                          logic [W-1:0] tx, logic [W-1:0] rp, bit inject);
    int h, s, p, first_sck, last_rise, rises, cs_rise, done_t, done_cnt, cs_falls, per_bad;
    bit prev_sck, prev_cs;
    logic [W-1:0] cap;
    h = exp_half(b); s = exp_setup(ss, sl, b); p = exp_hold(hs, hl);
    first_sck = -1; last_rise = -1; rises = 0; cs_rise = -1; done_t = -1;
    done_cnt = 0; cs_falls = 0; per_bad = 0; cap = '0;
    setup_sel = ss[0]; hold_sel = hs[0]; setup_len = 7'(sl); hold_len = 8'(hl);
    baud = 8'(b); tx_data = tx; rx_pat = rp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_n && !sck && busy, "R10", {cs_n, sck, busy}, 3'b001);
    prev_sck = sck; prev_cs = cs_n;
    for (int t = 1; t < 20000; t++) begin
      if (inject && t == 3) begin
        start = 1'b1; tx_data = ~tx; setup_sel = ~ss[0]; hold_sel = ~hs[0];
      end
      if (inject && t == 4) start = 1'b0;
      @(negedge clk);
      if (sck && !prev_sck) begin
        if (rises == 0) first_sck = t;
        else if (t - last_rise != 2 * h) per_bad++;
        if (rises < W) cap[W-1-rises] = mosi;
        last_rise = t; rises++;
      end
      if (cs_n && !prev_cs && cs_rise < 0) begin
        cs_rise = t;
        chk(rx_data == rp, "R8 rx", rx_data, rp);
      end
      if (!cs_n && prev_cs) cs_falls++;
      if (done) begin done_cnt++; if (done_t < 0) done_t = t; end
      prev_sck = sck; prev_cs = cs_n;
      if (done_t >= 0 && t >= done_t + 4) break;
    end
    chk(first_sck == s, (ss == 0) ? "R2" : ((sl < 2) ? "R4" : "R3"), first_sck, s);
    chk(rises == W && per_bad == 0, "R7", rises * 1000 + per_bad, W * 1000);
    chk(cap == tx, "R8 mosi", cap, tx);
    chk(cs_rise == s + (2 * W - 1) * h, "R9", cs_rise, s + (2 * W - 1) * h);
    chk(done_t - cs_rise == p, (hs == 0) ? "R6" : "R5", done_t - cs_rise, p);
    chk(done_cnt == 1 && cs_falls == 0 && !busy, "R10", done_cnt * 10 + cs_falls, 10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5171));
    @(negedge clk);
    chk(cs_n && !sck && !done && !busy, "R1", {cs_n, sck, done, busy}, 4'b1000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sck && !done && !busy, "R1", {cs_n, sck, done, busy}, 4'b1000);
    run_xfer(0, 0, 0, 0, 14, 8'hA5, 8'h3C, 0);     // R2 field ignored, R6
    run_xfer(1, 0, 0, 3, 3, 8'h81, 8'hC3, 0);      // R4 zero -> 128
    run_xfer(1, 1, 1, 0, 0, 8'h5A, 8'h96, 0);      // R4 one -> 2, R5 zero, R7 clamp
    run_xfer(1, 1, 127, 255, 1, 8'hFF, 8'h01, 0);  // R3 top, R5 top
    run_xfer(1, 0, 2, 1, 2, 8'h00, 8'hFE, 1);      // R10 start ignored while busy
    for (int i = 0; i < 8; i++)
      run_xfer($urandom % 2, $urandom % 2, $urandom % 128, $urandom % 256,
               $urandom % 21, 8'($urandom), 8'($urandom), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule